// File: doc/BRIEF.md
# Status Flag Register and Branch Condition Unit

This block keeps the four processor status flags and decides whether a branch is taken. Flag results from the ALU are stored when the current instruction is marked as one that sets flags. A shift can instead refresh only the carry flag through a separate enable. Instructions with neither enable leave the stored flags as they are.

A 4-bit condition selector picks one of sixteen tests over the stored flags. These include the signed and unsigned orderings, and the result appears combinationally on `take_o`. A second mode bypasses the flags and compares two register operands directly. That mode covers equality, inequality, and signed and unsigned less-than and greater-or-equal, and it never writes the flags. Flags written at a clock edge are seen by branches from the next cycle onward. A branch in the same cycle as a flag write still sees the old flags.

Top module: `cc_branch_unit`

## Requirements
- R1: While rst_ni is low, and after its release until the first write, flags_o reads 4'b0000.
- R2: When set_flags_i is high, all four flags are loaded from flags_i at the rising edge, with bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. take_o in the cycle of the write is evaluated on the flags held before that edge.
- R3: With set_flags_i and set_carry_i both low, flags_o holds its value across the edge, including cycles with cmp_mode_i high.
- R4: With set_carry_i high and set_flags_i low, only C takes carry_i and N, Z, V hold. When both enables are high, set_flags_i wins.
- R5: In flag mode (cmp_mode_i low), selector 0 always gives take_o = 1 and selector 1 always gives 0. For every even selector 2k (k ≥ 1), selector 2k+1 gives the inverse result.
- R6: Selector 2 is taken when Z = 1; selector 3 is taken when Z = 0.
- R7: Selector 4 (signed greater) is taken when Z = 0 and N = V. Selector 5 is its inverse. Selector 6 (signed greater-or-equal) is taken when N = V, and selector 7 is its inverse.
- R8: Selector 8 (unsigned greater) is taken when C = 0 and Z = 0, and selector 9 is its inverse. Selector 10 is taken when C = 0, and selector 11 when C = 1.
- R9: Selector 12 is taken when N = 0 and selector 13 when N = 1. Selector 14 is taken when V = 0 and selector 15 when V = 1.
- R10: In compare mode (cmp_mode_i high), cmp_op_i 0 is taken when opa_i equals opb_i and cmp_op_i 1 is taken when they differ. The result does not depend on the stored flags.
- R11: cmp_op_i 2 is taken when opa_i < opb_i as two's-complement values, and cmp_op_i 3 is taken when opa_i ≥ opb_i signed.
- R12: cmp_op_i 4 is taken when opa_i < opb_i unsigned and cmp_op_i 5 when opa_i ≥ opb_i unsigned. cmp_op_i 6 and 7 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_flags_i | input | 1 | Load all four flags from flags_i |
| flags_i | input | 4 | ALU flag result {N,Z,C,V} |
| set_carry_i | input | 1 | Load only the carry flag from carry_i |
| carry_i | input | 1 | Shift carry-out |
| cmp_mode_i | input | 1 | 1: compare operands, 0: test stored flags |
| cond_i | input | 4 | Flag condition selector |
| cmp_op_i | input | 3 | Operand comparison selector |
| opa_i | input | WIDTH | First compare operand |
| opb_i | input | WIDTH | Second compare operand |
| take_o | output | 1 | Branch taken |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench builds the unit with the default WIDTH of 32, so the sign bit of the subtractor sits at bit 31. Operands are drawn as raw 32-bit words, as copies of each other, and as values near 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. This reaches the cases where the signed and unsigned orderings disagree and where the subtraction overflows. Random flag vectors cover all sixteen flag combinations under every selector. A directed sequence writes the flags and branches in the same cycle to show the one-cycle dependency.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int unsigned FLAG_W = 4;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned OP_W   = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [SEL_W-2:0] {
    PAIR_ALW = 3'd0,
    PAIR_EQ  = 3'd1,
    PAIR_GT  = 3'd2,
    PAIR_GE  = 3'd3,
    PAIR_HI  = 3'd4,
    PAIR_CC  = 3'd5,
    PAIR_PL  = 3'd6,
    PAIR_VC  = 3'd7
  } cond_pair_e;

  typedef enum logic [OP_W-2:0] {
    CMP_EQ  = 2'd0,
    CMP_LT  = 2'd1,
    CMP_LTU = 2'd2,
    CMP_RSV = 2'd3
  } cmp_pair_e;
endpackage

// File: rtl/cc_flag_reg.sv
module cc_flag_reg
  import cc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_flags_i,
  input  flags_t flags_i,
  input  logic   set_carry_i,
  input  logic   carry_i,
  output flags_t flags_q_o
);
  flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (set_flags_i)      flags_d = flags_i;
    else if (set_carry_i) flags_d.c = carry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/cc_cond_eval.sv
module cc_cond_eval
  import cc_pkg::*;
(
  input  flags_t           flags_i,
  input  logic [SEL_W-1:0] cond_i,
  output logic             take_o
);
  cond_pair_e pair;
  logic       base;
  logic       sgn_lt;

  assign pair   = cond_pair_e'(cond_i[SEL_W-1:1]);
  assign sgn_lt = flags_i.n ^ flags_i.v;

  always_comb begin
    unique case (pair)
      PAIR_ALW: base = 1'b1;
      PAIR_EQ:  base = flags_i.z;
      PAIR_GT:  base = ~(flags_i.z | sgn_lt);
      PAIR_GE:  base = ~sgn_lt;
      PAIR_HI:  base = ~(flags_i.c | flags_i.z);
      PAIR_CC:  base = ~flags_i.c;
      PAIR_PL:  base = ~flags_i.n;
      PAIR_VC:  base = ~flags_i.v;
      default:  base = 1'b0;
    endcase
  end

  // odd selector inverts its pair
  assign take_o = base ^ cond_i[0];
endmodule

// File: rtl/cc_cmp_eval.sv
module cc_cmp_eval
  import cc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [OP_W-1:0]  cmp_op_i,
  output logic             take_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0] diff;
  logic           borrow, zero, ovf, neg, base, valid;
  cmp_pair_e      pair;

  assign diff   = {1'b0, opa_i} - {1'b0, opb_i};
  assign borrow = diff[WIDTH];
  assign zero   = (diff[MSB:0] == '0);
  assign neg    = diff[MSB];
  assign ovf    = (opa_i[MSB] ^ opb_i[MSB]) & (opa_i[MSB] ^ diff[MSB]);
  assign pair   = cmp_pair_e'(cmp_op_i[OP_W-1:1]);

  always_comb begin
    valid = 1'b1;
    unique case (pair)
      CMP_EQ:  base = zero;
      CMP_LT:  base = neg ^ ovf;
      CMP_LTU: base = borrow;
      default: begin
        base  = 1'b0;
        valid = 1'b0;
      end
    endcase
  end

  assign take_o = valid & (base ^ cmp_op_i[0]);
endmodule

// File: rtl/cc_branch_unit.sv
module cc_branch_unit
  import cc_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_flags_i,
  input  logic [3:0]        flags_i,
  input  logic              set_carry_i,
  input  logic              carry_i,
  input  logic              cmp_mode_i,
  input  logic [3:0]        cond_i,
  input  logic [2:0]        cmp_op_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  output logic              take_o,
  output logic [3:0]        flags_o
);
  flags_t flags_q;
  logic   cond_take, cmp_take;

  cc_flag_reg u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_flags_i (set_flags_i),
    .flags_i     (flags_t'(flags_i)),
    .set_carry_i (set_carry_i),
    .carry_i     (carry_i),
    .flags_q_o   (flags_q)
  );

  cc_cond_eval u_cond (
    .flags_i (flags_q),
    .cond_i  (cond_i),
    .take_o  (cond_take)
  );

  cc_cmp_eval #(.WIDTH(WIDTH)) u_cmp (
    .opa_i    (opa_i),
    .opb_i    (opb_i),
    .cmp_op_i (cmp_op_i),
    .take_o   (cmp_take)
  );

  assign take_o  = cmp_mode_i ? cmp_take : cond_take;
  assign flags_o = flags_q;
endmodule

// File: rtl/cc_branch_unit_chk.sv
module cc_branch_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             set_flags_i,
  input logic [3:0]       flags_i,
  input logic             set_carry_i,
  input logic             carry_i,
  input logic             cmp_mode_i,
  input logic [3:0]       cond_i,
  input logic [2:0]       cmp_op_i,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic             take_o,
  input logic [3:0]       flags_o
);
  always_comb begin
    if (!rst_ni) p_reset_zero_r1: assert (flags_o == 4'b0000);
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flags_i |=> flags_o == $past(flags_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && !set_carry_i) |=> $stable(flags_o));

  p_carry_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_flags_i && set_carry_i) |=>
      (flags_o[1] == $past(carry_i)) && (flags_o[3:2] == $past(flags_o[3:2]))
      && (flags_o[0] == $past(flags_o[0])));

  p_never_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_mode_i && cond_i == 4'd1) |-> !take_o);

  p_always_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_mode_i && cond_i == 4'd0) |-> take_o);

  p_cmp_eq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && cmp_op_i == 3'd0) |-> take_o == (opa_i == opb_i));

  p_cmp_ltu_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && cmp_op_i == 3'd4) |-> take_o == (opa_i < opb_i));

  p_cmp_rsv_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && cmp_op_i[2:1] == 2'b11) |-> !take_o);
endmodule

bind cc_branch_unit cc_branch_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_flags_i (set_flags_i),
  .flags_i     (flags_i),
  .set_carry_i (set_carry_i),
  .carry_i     (carry_i),
  .cmp_mode_i  (cmp_mode_i),
  .cond_i      (cond_i),
  .cmp_op_i    (cmp_op_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .take_o      (take_o),
  .flags_o     (flags_o)
);

// File: tb/sim_cc_branch_unit.sv
`timescale 1ns/1ps
module sim_cc_branch_unit;
  localparam int unsigned WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             set_flags = 1'b0;
  logic [3:0]       flags_in = '0;
  logic             set_carry = 1'b0;
  logic             carry_in = 1'b0;
  logic             cmp_mode = 1'b0;
  logic [3:0]       cond = '0;
  logic [2:0]       cmp_op = '0;
  logic [WIDTH-1:0] opa = '0;
  logic [WIDTH-1:0] opb = '0;
  logic             take;
  logic [3:0]       flags_out;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [3:0]  model = '0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  cc_branch_unit #(.WIDTH(WIDTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .set_flags_i(set_flags), .flags_i(flags_in),
    .set_carry_i(set_carry), .carry_i(carry_in), .cmp_mode_i(cmp_mode),
    .cond_i(cond), .cmp_op_i(cmp_op), .opa_i(opa), .opb_i(opb),
    .take_o(take), .flags_o(flags_out)
  );

  // flags {N,Z,C,V}
  function automatic logic cond_ref(input logic [3:0] s, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (s)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return z;
      4'd3:  return !z;
      4'd4:  return !z && (n == v);
      4'd5:  return z || (n != v);
      4'd6:  return n == v;
      4'd7:  return n != v;
      4'd8:  return !c && !z;
      4'd9:  return c || z;
      4'd10: return !c;
      4'd11: return c;
      4'd12: return !n;
      4'd13: return n;
      4'd14: return !v;
      default: return v;
    endcase
  endfunction

  function automatic logic cmp_ref(input logic [2:0] op, input logic [WIDTH-1:0] a,
                                   input logic [WIDTH-1:0] b);
    case (op)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return $signed(a) < $signed(b);
      3'd3: return $signed(a) >= $signed(b);
      3'd4: return a < b;
      3'd5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] s);
    if (s < 4'd2)  return "R5";
    if (s < 4'd4)  return "R6";
    if (s < 4'd8)  return "R7";
    if (s < 4'd12) return "R8";
    return "R9";
  endfunction

  function automatic string cmp_tag(input logic [2:0] op);
    if (op < 3'd2) return "R10";
    if (op < 3'd4) return "R11";
    return "R12";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] pick_op();
    case ($urandom_range(0, 5))
      0: return '0;
      1: return {1'b0, {(WIDTH-1){1'b1}}};
      2: return {1'b1, {(WIDTH-1){1'b0}}};
      3: return '1;
      4: return WIDTH'($urandom_range(0, 3));
      default: return WIDTH'($urandom());
    endcase
  endfunction

  // one cycle: drive at negedge, check take before edge, check flags after edge
  task automatic step(input string ftag);
    #1;
    if (cmp_mode) check(cmp_tag(cmp_op), 32'(take), 32'(cmp_ref(cmp_op, opa, opb)));
    else          check(cond_tag(cond),  32'(take), 32'(cond_ref(cond, model)));
    @(posedge clk);
    if (set_flags)      model = flags_in;
    else if (set_carry) model[1] = carry_in;
    #1;
    check(ftag, 32'(flags_out), 32'(model));
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1;
    check("R1", 32'(flags_out), 32'h0);
    repeat (3) @(negedge clk);
    check("R1", 32'(flags_out), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(flags_out), 32'h0);

    // R2: write Z and branch on EQ in the same cycle -> old flags
    set_flags = 1'b1; flags_in = 4'b0100; cond = 4'd2;
    step("R2");
    set_flags = 1'b0;
    step("R3");
    // R4: both enables, set_flags wins
    set_flags = 1'b1; set_carry = 1'b1; flags_in = 4'b1001; carry_in = 1'b1; cond = 4'd11;
    step("R4");
    set_flags = 1'b0; carry_in = 1'b1; cond = 4'd11;
    step("R4");
    set_carry = 1'b0; cond = 4'd11;
    step("R3");
    // R10: compare mode ignores flags and leaves them
    cmp_mode = 1'b1; cmp_op = 3'd0; opa = 32'h1234; opb = 32'h1234;
    step("R3");
    cmp_op = 3'd2; opa = 32'h8000_0000; opb = 32'h0000_0001;
    step("R3");
    cmp_op = 3'd4;
    step("R3");
    cmp_op = 3'd6; opa = 32'h0; opb = 32'h1;
    step("R3");
    cmp_mode = 1'b0;

    for (int i = 0; i < 6000; i++) begin
      set_flags = ($urandom_range(0, 3) == 0);
      set_carry = ($urandom_range(0, 3) == 0);
      flags_in  = 4'($urandom());
      carry_in  = 1'($urandom());
      cond      = 4'($urandom());
      cmp_mode  = ($urandom_range(0, 2) == 0);
      cmp_op    = 3'($urandom());
      opa       = pick_op();
      opb       = ($urandom_range(0, 4) == 0) ? opa : pick_op();
      if (set_flags)      step("R2");
      else if (set_carry) step("R4");
      else                step("R3");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule